// File: doc/BRIEF.md
# Four-Mode Parallel Shift Register

This block holds a small word in a bank of D flip-flops and, on every rising clock edge, performs one of four operations chosen by two control inputs: keep the stored word, capture a new word from the parallel input, move the word one place toward the most significant bit, or move it one place toward the least significant bit. Each bit's next value is picked by a four-way selector indexed by the two controls. The stored word is always visible on the parallel output.

Two dedicated serial inputs supply the bit that enters during a shift: one fills the vacated low end on a shift toward the MSB, the other fills the vacated high end on a shift toward the LSB. A synchronous, active-high reset clears the register and overrides every mode. The control coding is not the common one for such registers: the shift-enable control `shift_en` together with the load-or-direction control `load_dir` select, with `{shift_en, load_dir}` = 00 hold, 01 load, 10 shift toward MSB, 11 shift toward LSB.

Top module: `quad_mode_shreg`

## Requirements
- R1: With `rst` high at a rising edge, `q` becomes 0 after that edge, whatever the values of `shift_en` and `load_dir`.
- R2: With `{shift_en, load_dir}` = 00 and `rst` low, `q` after the edge equals `q` before it; `par_in`, `ser_lo` and `ser_hi` have no effect.
- R3: With `{shift_en, load_dir}` = 01 and `rst` low, `q` after the edge equals `par_in` sampled at that edge.
- R4: With `{shift_en, load_dir}` = 10 and `rst` low, `q[3:1]` takes the previous `q[2:0]` and `q[0]` takes `ser_lo`; the previous `q[3]` is lost.
- R5: With `{shift_en, load_dir}` = 11 and `rst` low, `q[2:0]` takes the previous `q[3:1]` and `q[3]` takes `ser_hi`; the previous `q[0]` is lost.
- R6: The register is 4 bits wide; `par_in` is ignored in both shift modes, `ser_lo` is ignored in every mode but 10, and `ser_hi` in every mode but 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| shift_en | input | 1 | High selects a shift mode |
| load_dir | input | 1 | With shift_en low: load; with shift_en high: shift toward LSB |
| par_in | input | 4 | Parallel data captured in mode 01 |
| ser_lo | input | 1 | Bit entering q[0] in mode 10 |
| ser_hi | input | 1 | Bit entering q[3] in mode 11 |
| q | output | 4 | Stored word |

## Verification
Each mode is driven with walking-one and alternating patterns so a bit sent to the wrong neighbour, or a swapped serial input, shows up as a visible mismatch. Four consecutive shifts in each direction with a known serial stream confirm the low and high ends both discard and fill correctly. Long random runs mix all four modes with random `par_in` and serial bits, which separates a swapped mode coding from a correct one, and hold cycles with changing inputs show that nothing unselected leaks in. Reset is asserted mid-run while each mode is selected to confirm its priority.

// File: rtl/qmsr_pkg.sv
package qmsr_pkg;

    localparam int unsigned WORD_W = 4;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        OP_KEEP    = 2'b00,
        OP_CAPTURE = 2'b01,
        OP_TO_MSB  = 2'b10,
        OP_TO_LSB  = 2'b11
    } op_e;

    typedef struct packed {
        word_t par;
        logic  fill_lo;
        logic  fill_hi;
    } feed_t;

    function automatic op_e decode_op(input logic sh, input logic ld);
        return op_e'({sh, ld});
    endfunction

endpackage

// File: rtl/qmsr_bit_mux.sv
module qmsr_bit_mux (
    input  logic       own_bit,
    input  logic       par_bit,
    input  logic       from_lower,
    input  logic       from_upper,
    input  logic [1:0] sel,
    output logic       next_bit
);
    always_comb begin
        unique case (sel)
            2'b00:   next_bit = own_bit;
            2'b01:   next_bit = par_bit;
            2'b10:   next_bit = from_lower;
            default: next_bit = from_upper;
        endcase
    end
endmodule

// File: rtl/qmsr_next_word.sv
module qmsr_next_word
    import qmsr_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] par,
    input  logic         fill_lo,
    input  logic         fill_hi,
    input  op_e          op,
    output logic [W-1:0] nxt
);
    localparam int unsigned TOP = W - 1;

    logic [W-1:0] lower_src;
    logic [W-1:0] upper_src;

    assign lower_src = {cur[TOP-1:0], fill_lo};
    assign upper_src = {fill_hi, cur[TOP:1]};

    for (genvar i = 0; i < W; i++) begin : g_bit
        qmsr_bit_mux u_mux (
            .own_bit    (cur[i]),
            .par_bit    (par[i]),
            .from_lower (lower_src[i]),
            .from_upper (upper_src[i]),
            .sel        (op),
            .next_bit   (nxt[i])
        );
    end
endmodule

// File: rtl/quad_mode_shreg.sv
module quad_mode_shreg
    import qmsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       shift_en,
    input  logic       load_dir,
    input  logic [3:0] par_in,
    input  logic       ser_lo,
    input  logic       ser_hi,
    output logic [3:0] q
);
    localparam int unsigned W = WORD_W;

    op_e   op;
    feed_t feed;
    word_t state_q;
    word_t state_d;

    assign op   = decode_op(shift_en, load_dir);
    assign feed = '{par: par_in, fill_lo: ser_lo, fill_hi: ser_hi};

    qmsr_next_word #(.W(W)) u_next (
        .cur     (state_q),
        .par     (feed.par),
        .fill_lo (feed.fill_lo),
        .fill_hi (feed.fill_hi),
        .op      (op),
        .nxt     (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign q = state_q;

    logic seen_clk;
    always_ff @(posedge clk) seen_clk <= 1'b1;

    AST_RESET_CLEARS: assert property (@(posedge clk) seen_clk && $past(rst) |-> q == '0); // R1
    AST_KEEP_STABLE: assert property (@(posedge clk) disable iff (rst)
        seen_clk && !$past(rst) && $past({shift_en, load_dir}) == 2'b00 |-> $stable(q)); // R2
    AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        seen_clk && !$past(rst) && $past({shift_en, load_dir}) == 2'b01 |-> q == $past(par_in)); // R3
    AST_TO_MSB: assert property (@(posedge clk) disable iff (rst)
        seen_clk && !$past(rst) && $past({shift_en, load_dir}) == 2'b10
        |-> q == {$past(q[2:0]), $past(ser_lo)}); // R4
    AST_TO_LSB: assert property (@(posedge clk) disable iff (rst)
        seen_clk && !$past(rst) && $past({shift_en, load_dir}) == 2'b11
        |-> q == {$past(ser_hi), $past(q[3:1])}); // R5
endmodule

// File: tb/quad_mode_shreg_test.sv
module quad_mode_shreg_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       shift_en;
    logic       load_dir;
    logic [3:0] par_in;
    logic       ser_lo;
    logic       ser_hi;
    logic [3:0] q;

    int n_checks = 0;
    int n_fail   = 0;
    int model    = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    quad_mode_shreg uut (
        .clk(clk), .rst(rst), .shift_en(shift_en), .load_dir(load_dir),
        .par_in(par_in), .ser_lo(ser_lo), .ser_hi(ser_hi), .q(q)
    );

    // behavioural reference: integer arithmetic, updated on each edge
    always @(posedge clk) begin
        if (rst) model <= 0;
        else if (!shift_en && load_dir) model <= int'(par_in);
        else if (shift_en && !load_dir) model <= ((model * 2) % 16) + int'(ser_lo);
        else if (shift_en && load_dir) model <= (model / 2) + (ser_hi ? 8 : 0);
    end

    task automatic check(input string req);
        n_checks++;
        if (int'(q) != model) begin
            n_fail++;
            $display("FAIL %s: q=%0h expected=%0h", req, q, model);
        end
    endtask

    task automatic step(input logic r, input logic s, input logic l,
                        input logic [3:0] p, input logic sl, input logic sr,
                        input string req);
        rst = r; shift_en = s; load_dir = l; par_in = p; ser_lo = sl; ser_hi = sr;
        @(posedge clk);
        #5;
        check(req);
    endtask

    initial begin
        rst = 1'b1; shift_en = 1'b1; load_dir = 1'b1; par_in = 4'hF; ser_lo = 1'b1; ser_hi = 1'b1;
        step(1, 1, 1, 4'hF, 1, 1, "R1 reset");
        step(0, 0, 1, 4'h1, 0, 0, "R3 load 1");
        step(0, 0, 1, 4'hA, 0, 0, "R3 load A");
        step(0, 0, 0, 4'h5, 1, 1, "R2 hold");
        step(0, 0, 0, 4'h3, 0, 1, "R2 R6 hold inputs ignored");
        step(0, 0, 1, 4'h1, 0, 0, "R3 load");
        for (int i = 0; i < 4; i++) step(0, 1, 0, 4'hF, i[0], 1, "R4 R6 toward MSB");
        step(0, 0, 1, 4'h8, 0, 0, "R3 load 8");
        for (int i = 0; i < 4; i++) step(0, 1, 1, 4'h0, 1, i[1], "R5 R6 toward LSB");
        step(0, 0, 1, 4'h9, 0, 0, "R3 load 9");
        step(0, 1, 0, 4'h0, 0, 1, "R4 msb discarded");
        step(0, 1, 1, 4'hF, 1, 0, "R5 lsb discarded");
        for (int m = 0; m < 4; m++) begin
            step(0, 0, 1, 4'h7, 0, 0, "R3 preload");
            step(1, m[1], m[0], 4'hF, 1, 1, "R1 reset priority");
        end
        for (int i = 0; i < 2000; i++) begin
            logic [6:0] r = 7'($urandom);
            step(($urandom % 50) == 0, r[0], r[1], r[5:2], r[6], 1'($urandom), "R2 R3 R4 R5 random");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: q=%0h expected=completion", q);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule